// File: doc/BRIEF.md
# Sampling ADC Serial Readout Master

This block is the host side of a serial link to an external 12-bit sampling converter. A start pulse makes it pull the active-low chip select low and toggle a serial clock. The converter begins its conversion on that first clock activity and shifts its result back on a single data line. The converter changes the data line on falling clock edges, so the master takes each bit on a rising edge. The serial clock is derived from the system clock. Each clock level is held for a programmable number of system cycles, with a minimum of two.

Two frame layouts are supported, chosen by a static format input that is captured when a frame is launched.
- **Split format:** the clock idles low and the result comes back as two 8-bit transfers separated by an idle gap.
- **Stream format:** the clock idles high and the result comes back as one 16-clock burst.

In both formats the master discards the framing bits, presents the 12-bit result with a one-cycle valid strobe, and raises an error flag when the zero marker or any pad bit reads as 1. When a frame ends, chip select must stay high long enough for the converter to reacquire its input. A start request that arrives during this acquisition window is held and is launched once the window has elapsed.

The controller is a seven-state machine.
- **ACQ:** chip select high, acquisition window counting.
- **IDLE:** ready to launch.
- **SETUP:** chip select low, clock still at its idle level for one half period.
- **LEAD:** first half of a bit.
- **TRAIL:** second half of a bit.
- **GAP:** split format only, one idle half period between the bytes.
- **DONE:** chip select released and result posted.

The transitions are:
- ACQ→IDLE when the window has elapsed.
- IDLE→SETUP on a start or a held request.
- SETUP→LEAD on a half-period tick.
- LEAD→TRAIL on a tick.
- TRAIL→LEAD on a tick when more bits remain.
- TRAIL→GAP on a tick after bit 7 in split format.
- GAP→LEAD on a tick.
- TRAIL→DONE on a tick after bit 15.
- DONE→ACQ unconditionally.

Top module: `sar_readout_master`

## Requirements
- R1: While reset is applied and right after it, cs_n is 1, sclk is 0, busy is 0, result_valid is 0 and frame_err is 0.
- R2: A start pulse accepted while the block is ready gives, one cycle later, busy=1 and cs_n=0, with sclk at the idle level of the selected format (fmt_sel=0 gives low, fmt_sel=1 gives high).
- R3: Every sclk level inside a frame lasts max(half_div,2) system cycles. A frame has exactly 16 rising sclk edges. While cs_n is high, sclk holds the idle level of the last captured format.
- R4: Split format (fmt_sel=0). The 16 received bits, first to last, are: one undefined bit, a 0 marker, result bits 11..6, result bits 5..0, then two 0 pad bits. The bytes are separated by sclk staying low for two half periods.
- R5: Stream format (fmt_sel=1). The 16 received bits, first to last, are: a 0 marker, result bits 11..0, then three 0 pad bits.
- R6: Each received bit is the value of sdata present just before the corresponding rising sclk edge.
- R7: result_valid is a single-cycle pulse in the cycle cs_n returns high. result changes only with result_valid.
- R8: frame_err is 1, only together with result_valid, when the marker bit or any pad bit was 1. The undefined first bit of the split format has no effect on frame_err or result.
- R9: cs_n stays high for at least acq_cycles cycles between frames. A start during that time is held, busy stays 1, and the frame launches once the time has elapsed.
- R10: fmt_sel is captured only at launch. Changing it mid-frame alters neither the frame nor the decoded result.
- R11: A start pulse during a frame (cs_n low) is ignored and launches no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to read one conversion |
| fmt_sel | input | 1 | Frame format: 0 split (idle low), 1 stream (idle high) |
| half_div | input | DIV_W | System cycles per sclk level (values below 2 act as 2) |
| acq_cycles | input | ACQ_W | Minimum cs_n high time between frames |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | Request accepted and chip select not yet released |
| result | output | 12 | Last decoded conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | Marker or pad bit was nonzero (with result_valid) |

## Verification
Most corrupted internal states appear at the pins within one frame.
- A wrong bit counter or a missed GAP transition changes the count of rising edges or the low run between the bytes, so the frame ends early or late. It also shifts the decoded result by a bit position and sets frame_err when a data bit lands on a pad slot.
- A wrong half-period counter shows up as an sclk level that does not last exactly the programmed number of cycles.
- A stale format register leaves the clock at the wrong idle level as soon as chip select falls.
- A broken acquisition counter shortens the chip-select high time before the next frame. The bench measures that time directly.

// File: rtl/sar_rd_pkg.sv
`timescale 1ns/1ps
package sar_rd_pkg;

    localparam int FRAME_LEN = 16;
    localparam int RES_LEN   = 12;
    localparam int BYTE_LEN  = 8;
    localparam int MIN_HALF  = 2;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef enum logic [2:0] {
        S_ACQ,
        S_IDLE,
        S_SETUP,
        S_LEAD,
        S_TRAIL,
        S_GAP,
        S_DONE
    } rd_state_e;

    typedef enum logic {
        FMT_SPLIT  = 1'b0,
        FMT_STREAM = 1'b1
    } rd_fmt_e;

    function automatic logic in_frame(rd_state_e s);
        return (s == S_SETUP) || (s == S_LEAD) || (s == S_TRAIL) || (s == S_GAP);
    endfunction

endpackage

// File: rtl/rd_half_timer.sv
`timescale 1ns/1ps
module rd_half_timer
    import sar_rd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;

    assign half_eff = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
    assign tick     = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= half_eff - DIV_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - DIV_W'(1);
        end
    end

    // after a reload the counter never ticks on the next cycle
    assert_reload_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/rd_acq_timer.sv
`timescale 1ns/1ps
module rd_acq_timer #(
    parameter int ACQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [ACQ_W-1:0] acq_cycles,
    output logic             done
);

    logic [ACQ_W-1:0] cnt;

    assign done = (cnt >= acq_cycles);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= '0;
        end else if (cnt < acq_cycles) begin
            cnt <= cnt + ACQ_W'(1);
        end
    end

    // chip select may only fall once the acquisition time was served
    assert_acq_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(done));

endmodule

// File: rtl/rd_frame_decode.sv
`timescale 1ns/1ps
module rd_frame_decode
    import sar_rd_pkg::*;
(
    input  rd_fmt_e                fmt,
    input  logic [FRAME_LEN-1:0]   frame,
    output logic [RES_LEN-1:0]     value,
    output logic                   bad
);

    localparam int SPLIT_PAD  = FRAME_LEN - 2 - RES_LEN;
    localparam int STREAM_PAD = FRAME_LEN - 1 - RES_LEN;

    always_comb begin
        unique case (fmt)
            FMT_SPLIT: begin
                value = frame[FRAME_LEN-3 -: RES_LEN];
                bad   = frame[FRAME_LEN-2] | (|frame[SPLIT_PAD-1:0]);
            end
            FMT_STREAM: begin
                value = frame[FRAME_LEN-2 -: RES_LEN];
                bad   = frame[FRAME_LEN-1] | (|frame[STREAM_PAD-1:0]);
            end
            default: begin
                value = '0;
                bad   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sar_readout_master.sv
`timescale 1ns/1ps
module sar_readout_master
    import sar_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int ACQ_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               fmt_sel,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [ACQ_W-1:0]   acq_cycles,
    input  logic               sdata,
    output logic               cs_n,
    output logic               sclk,
    output logic               busy,
    output logic [RES_LEN-1:0] result,
    output logic               result_valid,
    output logic               frame_err
);

    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] BYTE_END = IDX_W'(BYTE_LEN - 1);

    rd_state_e            state, nxt;
    rd_fmt_e              fmt_q, fmt_n;
    logic [IDX_W-1:0]     bit_idx;
    logic [FRAME_LEN-1:0] shreg;
    logic                 pend, pend_n;
    logic                 tick, acq_done;
    logic                 launch, sclk_n, rise_n;
    logic [RES_LEN-1:0]   dec_value;
    logic                 dec_bad;

    rd_half_timer #(.DIV_W(DIV_W)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (nxt != state),
        .half_div (half_div),
        .tick     (tick)
    );

    rd_acq_timer #(.ACQ_W(ACQ_W)) u_acq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cs_n),
        .acq_cycles (acq_cycles),
        .done       (acq_done)
    );

    rd_frame_decode u_dec (
        .fmt   (fmt_q),
        .frame (shreg),
        .value (dec_value),
        .bad   (dec_bad)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_ACQ:   if (acq_done) nxt = S_IDLE;
            S_IDLE:  if ((start || pend) && acq_done) nxt = S_SETUP;
            S_SETUP: if (tick) nxt = S_LEAD;
            S_LEAD:  if (tick) nxt = S_TRAIL;
            S_TRAIL: begin
                if (tick) begin
                    if (bit_idx == LAST_BIT)
                        nxt = S_DONE;
                    else if (fmt_q == FMT_SPLIT && bit_idx == BYTE_END)
                        nxt = S_GAP;
                    else
                        nxt = S_LEAD;
                end
            end
            S_GAP:   if (tick) nxt = S_LEAD;
            S_DONE:  nxt = S_ACQ;
            default: nxt = S_ACQ;
        endcase
    end

    assign launch = (state == S_IDLE) && (nxt == S_SETUP);
    assign fmt_n  = launch ? rd_fmt_e'(fmt_sel) : fmt_q;

    // clock level of the next state; the idle level equals the format code
    always_comb begin
        unique case (nxt)
            S_LEAD:  sclk_n = ~fmt_n;
            S_TRAIL: sclk_n = fmt_n;
            default: sclk_n = fmt_n;
        endcase
        rise_n = sclk_n && !sclk && (nxt == S_LEAD || nxt == S_TRAIL);
    end

    always_comb begin
        pend_n = pend;
        if (launch)
            pend_n = 1'b0;
        else if (start && (state == S_ACQ || state == S_DONE || state == S_IDLE))
            pend_n = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_ACQ;
        else        state <= nxt;
    end

    // frame bookkeeping: format, bit index, receive shifter, held request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q   <= FMT_SPLIT;
            bit_idx <= '0;
            shreg   <= '0;
            pend    <= 1'b0;
        end else begin
            fmt_q <= fmt_n;
            pend  <= pend_n;
            if (launch)
                bit_idx <= '0;
            else if (state == S_TRAIL && tick)
                bit_idx <= bit_idx + IDX_W'(1);
            if (rise_n)
                shreg <= {shreg[FRAME_LEN-2:0], sdata};
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n         <= 1'b1;
            sclk         <= 1'b0;
            busy         <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            cs_n <= !in_frame(nxt);
            sclk <= sclk_n;
            busy <= pend_n || in_frame(nxt);
            if (nxt == S_DONE) begin
                result       <= dec_value;
                result_valid <= 1'b1;
                frame_err    <= dec_bad;
            end else begin
                result_valid <= 1'b0;
                frame_err    <= 1'b0;
            end
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_valid_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(cs_n));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    assert_half_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) || $fell(sclk)) |=> $stable(sclk));

    assert_idle_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(sclk));

    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !cs_n));

    assert_fmt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(fmt_q));

    assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> result_valid);

endmodule

// File: tb/sim_sar_readout_master.sv
`timescale 1ns/1ps
module sim_sar_readout_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_sel = 1'b0;
    logic [7:0]  half_div = 8'd2;
    logic [11:0] acq_cycles = 12'd6;
    logic        sdata = 1'b0;
    logic        cs_n, sclk, busy, result_valid, frame_err;
    logic [11:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sar_readout_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
        .half_div(half_div), .acq_cycles(acq_cycles), .sdata(sdata),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .result(result),
        .result_valid(result_valid), .frame_err(frame_err)
    );

    // converter model and port monitor
    logic [15:0] adc_frame = '0;
    logic        adc_fmt = 1'b0;
    int          ptr = 0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;
    int rises = 0, cur_run = 0, min_run = 0, max_run = 0, hi_run = 0, last_hi = 0;
    int got_rises = 0, got_min = 0, got_max = 0, double_valid = 0;

    always @(negedge clk) begin
        if (!cs_n && prev_cs) begin
            if (adc_fmt == 1'b0) begin sdata <= adc_frame[15]; ptr = 14; end
            else begin sdata <= 1'b1; ptr = 15; end
            rises = 0; cur_run = 1; min_run = 9999; max_run = 0; last_hi = hi_run;
        end else if (!cs_n) begin
            if (sclk != prev_sclk) begin
                if (cur_run < min_run) min_run = cur_run;
                if (cur_run > max_run) max_run = cur_run;
                cur_run = 1;
                if (sclk) rises++;
                else if (ptr >= 0) begin sdata <= adc_frame[ptr]; ptr--; end
            end else cur_run++;
        end
        if (cs_n) hi_run = prev_cs ? hi_run + 1 : 1;
        if (result_valid) begin
            got_rises = rises; got_min = min_run; got_max = max_run;
            if (prev_valid) double_valid++;
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_valid = result_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] build(input logic f, input logic [11:0] d,
                                          input logic unk, input logic mk, input logic pad);
        if (f == 1'b0) return {unk, mk, d, 1'b0, pad};
        else           return {mk, d, pad, 2'b00};
    endfunction

    task automatic wait_ready();
        while (!(cs_n && !busy)) @(negedge clk);
        repeat (int'(acq_cycles) + 4) @(negedge clk);
    endtask

    task automatic wait_valid(output bit ok);
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (result_valid) begin ok = 1; break; end
        end
        #1;
    endtask

    task automatic run_frame(input string tag, input logic f, input logic [11:0] d,
                             input logic unk, input logic mk, input logic pad,
                             input logic [7:0] hd, input bit flip, input bit mid_start);
        bit ok;
        int h = (hd < 2) ? 2 : int'(hd);
        wait_ready();
        half_div = hd; fmt_sel = f; adc_fmt = f; adc_frame = build(f, d, unk, mk, pad);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy"}, busy, 1);
        chk(cs_n == 1'b0, {tag, " R2 cs_n"}, cs_n, 0);
        chk(sclk == f, {tag, " R2 idle level"}, sclk, f);
        if (flip) begin repeat (6) @(negedge clk); fmt_sel = ~f; end
        if (mid_start) begin
            repeat (9) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_valid(ok);
        chk(ok, {tag, " R7 valid seen"}, ok, 1);
        chk(result == d, {tag, " R4/R5/R6 result"}, result, d);
        chk(frame_err == (mk | pad), {tag, " R8 frame_err"}, frame_err, mk | pad);
        chk(got_rises == 16, {tag, " R3 rising edges"}, got_rises, 16);
        chk(got_min == h, {tag, " R3 half period"}, got_min, h);
        chk(got_max == (f ? h : 2 * h), {tag, " R4 byte gap"}, got_max, f ? h : 2 * h);
        chk(cs_n == 1'b1 && sclk == f, {tag, " R7/R3 release level"}, sclk, f);
        @(negedge clk);
        chk(result_valid == 1'b0 && double_valid == 0, {tag, " R7 pulse width"}, result_valid, 0);
        fmt_sel = f;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !busy && !result_valid && !frame_err, "R1 in reset", cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && !busy && !result_valid && !frame_err, "R1 after reset", busy, 0);
    endtask

    task automatic t_midstart_ignored_R11();
        int lows = 0;
        run_frame("R11 frame", 1'b0, 12'h5A3, 1'b0, 1'b0, 1'b0, 8'd3, 0, 1);
        for (int i = 0; i < int'(acq_cycles) + 40; i++) begin
            @(negedge clk);
            if (!cs_n || busy) lows++;
        end
        chk(lows == 0, "R11 no extra frame", lows, 0);
    endtask

    task automatic t_acq_hold_R9();
        bit ok;
        int busy_lo = 0;
        acq_cycles = 12'd30;
        run_frame("R9 first", 1'b1, 12'h0F0, 1'b0, 1'b0, 1'b0, 8'd2, 0, 0);
        adc_frame = build(1'b1, 12'hB2D, 1'b0, 1'b0, 1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (cs_n) begin
            if (!busy) busy_lo++;
            @(negedge clk);
        end
        chk(busy_lo == 0, "R9 busy held", busy_lo, 0);
        #1;
        chk(last_hi >= 30, "R9 acquisition time", last_hi, 30);
        wait_valid(ok);
        chk(ok && result == 12'hB2D, "R9 held start frame", result, 12'hB2D);
        acq_cycles = 12'd6;
    endtask

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        run_frame("split basic",   1'b0, 12'hA5C, 1'b0, 1'b0, 1'b0, 8'd2, 0, 0);
        run_frame("stream basic",  1'b1, 12'h3E1, 1'b1, 1'b0, 1'b0, 8'd3, 0, 0);
        run_frame("R8 unk ignored",1'b0, 12'hFFF, 1'b1, 1'b0, 1'b0, 8'd2, 0, 0);
        run_frame("R8 bad marker", 1'b0, 12'h123, 1'b0, 1'b1, 1'b0, 8'd4, 0, 0);
        run_frame("R8 bad pad",    1'b1, 12'h800, 1'b0, 1'b0, 1'b1, 8'd2, 0, 0);
        run_frame("R5 clamp",      1'b1, 12'h001, 1'b0, 1'b0, 1'b0, 8'd0, 0, 0);
        run_frame("R10 flip",      1'b0, 12'h6B9, 1'b0, 1'b0, 1'b0, 8'd3, 1, 0);
        t_midstart_ignored_R11();
        t_acq_hold_R9();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule